// File: doc/BRIEF.md
# Eight-Port Parallel I/O Bank

This block hangs on an 8-bit I/O bus and gives the processor eight 8-bit parallel ports, 64 lines in all. Each port is fixed by a parameter to one of three kinds: a pure input, a write-only output latch, or an output latch whose value the processor can read back. Read back makes the latch usable as a scratch data register, and it lets software confirm what it wrote.

The bank claims eight consecutive I/O addresses. Two parameters set its base. A one-hot coarse select picks one of eight 32-address regions, and a one-hot fine select picks one of four 8-address slices inside that region. Because the base is built from these two selects, it always lands on a multiple of eight. The three lowest address bits pick the port within the bank. Write data is captured on the clock edge. Read data comes back combinationally from the present state of the port, and a bus-drive flag reports when the bank is driving the data bus.

Top module: `pio_bank`

## Requirements
- R1: While `rst` is high at a rising clock edge, every output latch is cleared to zero, and all 64 bits of `pin_out` read 0 after that edge.
- R2: A write hit loads `wdata` into the latch of port `addr[2:0]` at that rising edge when the port is configured as output (code 1) or output-with-readback (code 2). A write hit needs `wr`, `io_req` and `io_exp_en` high and the address inside the bank. Port p drives `pin_out[8p+7:8p]`, and `PORT_CFG[2p+1:2p]` holds the port's code.
- R3: A latch keeps its value until a write hit addresses that same port or a reset occurs. Writes to other ports and all bus activity outside the bank leave it unchanged.
- R4: When either `io_req` or `io_exp_en` is low, writes have no effect and reads leave `rdata_oe` low.
- R5: The bank answers only at addresses whose bits [7:5] equal the index of the set bit in `COARSE_SEL` and whose bits [4:3] equal the index of the set bit in `FINE_SEL`. The defaults place it at 00h..07h.
- R6: A read hit on an input port (code 0) returns that port's `pin_in` field in the same cycle, with `rdata_oe` high.
- R7: A read hit on a readback port (code 2) returns the latched value, not the pins, with `rdata_oe` high.
- R8: When the bank does not drive the bus, `rdata` is 8'hFF and `rdata_oe` is low. This covers a read of a write-only output port (code 1), an address outside the bank, and `rd` low.
- R9: A write hit on an input port changes nothing, and that port's `pin_out` field stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset, clears output latches |
| io_req | input | 1 | I/O cycle in progress |
| io_exp_en | input | 1 | I/O expansion enable, qualifies decoding |
| addr | input | 8 | I/O address |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| pin_in | input | 64 | Port input lines, port p at bits [8p+7:8p] |
| pin_out | output | 64 | Port output lines, port p at bits [8p+7:8p] |
| rdata | output | 8 | Read data, 8'hFF when not driven |
| rdata_oe | output | 1 | Bank drives the data bus |

## Verification
The assertions assume that `rd`, `wr`, `io_req`, `io_exp_en`, `addr` and `wdata` are known and settled at each rising edge. They also assume that `pin_in` changes only between edges. The bench meets both by driving every input just after the falling edge, and it checks read data one nanosecond later, well before the next rising edge. Random addresses are weighted toward the default bank and toward a second, relocated instance. The remaining addresses roam the whole space, so hits, misses and both enables are all exercised against a reference model of the latches.

// File: rtl/pio_pkg.sv
package pio_pkg;
   typedef enum logic [1:0] {
      PM_INPUT   = 2'd0,
      PM_OUTPUT  = 2'd1,
      PM_OUT_RB  = 2'd2
   } port_mode_e;

   function automatic logic [1:0] cfg_field(input logic [63:0] cfg, input int idx);
      return cfg[2*idx +: 2];
   endfunction
endpackage

// File: rtl/pio_decode.sv
module pio_decode #(
   parameter int AW      = 8,
   parameter int NPORTS  = 8,
   parameter int FINE_N  = 4,
   localparam int PB     = $clog2(NPORTS),
   localparam int FB     = $clog2(FINE_N),
   localparam int CB     = AW - PB - FB,
   parameter logic [(1<<CB)-1:0] COARSE_SEL = 1,
   parameter logic [FINE_N-1:0]  FINE_SEL   = 1
) (
   input  logic              io_req,
   input  logic              io_exp_en,
   input  logic [AW-1:0]     addr,
   input  logic              wr,
   input  logic              rd,
   output logic [NPORTS-1:0] wr_stb,
   output logic              rd_hit,
   output logic [PB-1:0]     port_idx
);
   logic [CB-1:0] coarse_f;
   logic [FB-1:0] fine_f;
   logic          card_hit;

   assign port_idx = addr[PB-1:0];
   assign fine_f   = addr[PB +: FB];
   assign coarse_f = addr[AW-1 -: CB];
   assign card_hit = io_req & io_exp_en & COARSE_SEL[coarse_f] & FINE_SEL[fine_f];
   assign rd_hit   = card_hit & rd;

   for (genvar i = 0; i < NPORTS; i++) begin : g_stb
      assign wr_stb[i] = card_hit & wr & (port_idx == PB'(i));
   end
endmodule

// File: rtl/pio_port.sv
module pio_port
   import pio_pkg::*;
#(
   parameter int         DW   = 8,
   parameter port_mode_e MODE = PM_OUT_RB
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          wr_stb,
   input  logic [DW-1:0] wdata,
   input  logic [DW-1:0] pin_in,
   output logic [DW-1:0] pin_out,
   output logic [DW-1:0] rd_val,
   output logic          readable
);
   if (MODE == PM_INPUT) begin : g_in
      assign pin_out  = '0;
      assign rd_val   = pin_in;
      assign readable = 1'b1;
   end else begin : g_out
      logic [DW-1:0] lat_q;
      always_ff @(posedge clk) begin
         if (rst)         lat_q <= '0;
         else if (wr_stb) lat_q <= wdata;
      end
      assign pin_out = lat_q;
      if (MODE == PM_OUT_RB) begin : g_rb
         assign rd_val   = lat_q;
         assign readable = 1'b1;
      end else begin : g_wo
         assign rd_val   = pin_in;
         assign readable = 1'b0;
      end
   end
endmodule

// File: rtl/pio_rdmux.sv
module pio_rdmux #(
   parameter int DW     = 8,
   parameter int NPORTS = 8,
   localparam int PB    = $clog2(NPORTS)
) (
   input  logic                 rd_hit,
   input  logic [PB-1:0]        port_idx,
   input  logic [NPORTS*DW-1:0] rd_val,
   input  logic [NPORTS-1:0]    readable,
   output logic [DW-1:0]        rdata,
   output logic                 rdata_oe
);
   assign rdata_oe = rd_hit & readable[port_idx];
   assign rdata    = rdata_oe ? rd_val[port_idx*DW +: DW] : '1;
endmodule

// File: rtl/pio_bank.sv
module pio_bank
   import pio_pkg::*;
#(
   parameter int DW     = 8,
   parameter int NPORTS = 8,
   parameter int AW     = 8,
   parameter int FINE_N = 4,
   parameter logic [2*NPORTS-1:0] PORT_CFG = 16'h50A8,
   parameter logic [(1<<(AW-$clog2(NPORTS)-$clog2(FINE_N)))-1:0] COARSE_SEL = 1,
   parameter logic [FINE_N-1:0] FINE_SEL = 1
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 io_req,
   input  logic                 io_exp_en,
   input  logic [AW-1:0]        addr,
   input  logic                 wr,
   input  logic                 rd,
   input  logic [DW-1:0]        wdata,
   input  logic [NPORTS*DW-1:0] pin_in,
   output logic [NPORTS*DW-1:0] pin_out,
   output logic [DW-1:0]        rdata,
   output logic                 rdata_oe
);
   localparam int PB = $clog2(NPORTS);

   if (DW < 1)                          $error("data width must be positive");
   if ((1 << PB) != NPORTS)             $error("port count must be a power of two");
   if (FINE_N < 2 || (1 << $clog2(FINE_N)) != FINE_N) $error("fine select width invalid");
   if ($countones(COARSE_SEL) != 1)     $error("coarse select must be one-hot");
   if ($countones(FINE_SEL) != 1)       $error("fine select must be one-hot");

   logic [NPORTS-1:0]    wr_stb;
   logic [NPORTS-1:0]    readable;
   logic [NPORTS*DW-1:0] rd_val;
   logic                 rd_hit;
   logic [PB-1:0]        port_idx;

   pio_decode #(
      .AW(AW), .NPORTS(NPORTS), .FINE_N(FINE_N),
      .COARSE_SEL(COARSE_SEL), .FINE_SEL(FINE_SEL)
   ) u_dec (
      .io_req(io_req), .io_exp_en(io_exp_en), .addr(addr),
      .wr(wr), .rd(rd), .wr_stb(wr_stb), .rd_hit(rd_hit), .port_idx(port_idx)
   );

   for (genvar p = 0; p < NPORTS; p++) begin : g_port
      localparam logic [1:0] CODE = PORT_CFG[2*p +: 2];
      if (CODE == 2'd3) $error("port configuration code 3 is reserved");
      pio_port #(.DW(DW), .MODE(port_mode_e'(CODE))) u_port (
         .clk(clk), .rst(rst), .wr_stb(wr_stb[p]), .wdata(wdata),
         .pin_in(pin_in[p*DW +: DW]), .pin_out(pin_out[p*DW +: DW]),
         .rd_val(rd_val[p*DW +: DW]), .readable(readable[p])
      );
   end

   pio_rdmux #(.DW(DW), .NPORTS(NPORTS)) u_mux (
      .rd_hit(rd_hit), .port_idx(port_idx), .rd_val(rd_val),
      .readable(readable), .rdata(rdata), .rdata_oe(rdata_oe)
   );
endmodule

// File: rtl/pio_bank_chk.sv
module pio_bank_chk #(
   parameter int DW     = 8,
   parameter int NPORTS = 8,
   parameter int AW     = 8,
   parameter int FINE_N = 4,
   parameter logic [2*NPORTS-1:0] PORT_CFG = 16'h50A8,
   parameter logic [(1<<(AW-$clog2(NPORTS)-$clog2(FINE_N)))-1:0] COARSE_SEL = 1,
   parameter logic [FINE_N-1:0] FINE_SEL = 1
) (
   input logic                 clk,
   input logic                 rst,
   input logic                 io_req,
   input logic                 io_exp_en,
   input logic [AW-1:0]        addr,
   input logic                 wr,
   input logic                 rd,
   input logic [DW-1:0]        wdata,
   input logic [NPORTS*DW-1:0] pin_in,
   input logic [NPORTS*DW-1:0] pin_out,
   input logic [DW-1:0]        rdata,
   input logic                 rdata_oe
);
   localparam int PB = $clog2(NPORTS);
   localparam int FB = $clog2(FINE_N);
   localparam int CB = AW - PB - FB;

   function automatic int bit_pos(input logic [63:0] v);
      int r = 0;
      for (int k = 0; k < 64; k++) if (v[k]) r = k;
      return r;
   endfunction

   localparam int CIDX = bit_pos(64'(COARSE_SEL));
   localparam int FIDX = bit_pos(64'(FINE_SEL));
   localparam logic [AW-PB-1:0] BASE_HI = {CB'(CIDX), FB'(FIDX)};

   logic in_bank, wr_any;
   assign in_bank = io_req && io_exp_en && (addr[AW-1:PB] == BASE_HI);
   assign wr_any  = in_bank && wr;

   a_r1_reset_clears: assert property (@(posedge clk) rst |=> pin_out == '0);
   a_r3_hold: assert property (@(posedge clk) disable iff (rst)
      !wr_any |=> $stable(pin_out));
   a_r4_gate_enables: assert property (@(posedge clk) disable iff (rst)
      !(io_req && io_exp_en) |-> !rdata_oe);
   a_r5_outside_silent: assert property (@(posedge clk) disable iff (rst)
      (addr[AW-1:PB] != BASE_HI) |-> !rdata_oe);
   a_r8_idle_ff: assert property (@(posedge clk) disable iff (rst)
      !rdata_oe |-> rdata == '1);

   for (genvar p = 0; p < NPORTS; p++) begin : g_chk
      localparam logic [1:0] CODE = PORT_CFG[2*p +: 2];
      if (CODE == 2'd0) begin : g_in
         a_r6_live_pins: assert property (@(posedge clk) disable iff (rst)
            (in_bank && rd && addr[PB-1:0] == PB'(p)) |-> (rdata_oe && rdata == pin_in[p*DW +: DW]));
      end else begin : g_out
         a_r2_write_lands: assert property (@(posedge clk) disable iff (rst)
            (wr_any && addr[PB-1:0] == PB'(p)) |=> pin_out[p*DW +: DW] == $past(wdata));
         if (CODE == 2'd2) begin : g_rb
            a_r7_readback: assert property (@(posedge clk) disable iff (rst)
               (in_bank && rd && addr[PB-1:0] == PB'(p)) |-> (rdata_oe && rdata == pin_out[p*DW +: DW]));
         end
      end
   end
endmodule

bind pio_bank pio_bank_chk #(
   .DW(DW), .NPORTS(NPORTS), .AW(AW), .FINE_N(FINE_N),
   .PORT_CFG(PORT_CFG), .COARSE_SEL(COARSE_SEL), .FINE_SEL(FINE_SEL)
) u_chk (.*);

// File: tb/pio_bank_test.sv
module pio_bank_test;
   localparam logic [15:0] CFG = 16'h50A8;
   localparam logic [7:0]  BASE_A = 8'h00;
   localparam logic [7:0]  BASE_B = 8'hB0;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic io_req = 1'b0, io_exp_en = 1'b0, wr = 1'b0, rd = 1'b0;
   logic [7:0]  addr = '0, wdata = '0;
   logic [63:0] pin_in = '0;
   logic [63:0] pout_a, pout_b;
   logic [7:0]  rdata_a, rdata_b;
   logic        oe_a, oe_b;

   logic [63:0] lat_a = '0, lat_b = '0;
   int n_chk = 0, n_bad = 0;
   bit done = 0;

   always #2 clk = ~clk;

   pio_bank uut (
      .clk(clk), .rst(rst), .io_req(io_req), .io_exp_en(io_exp_en), .addr(addr),
      .wr(wr), .rd(rd), .wdata(wdata), .pin_in(pin_in), .pin_out(pout_a),
      .rdata(rdata_a), .rdata_oe(oe_a));

   pio_bank #(.COARSE_SEL(8'b0010_0000), .FINE_SEL(4'b0100)) uut_hi (
      .clk(clk), .rst(rst), .io_req(io_req), .io_exp_en(io_exp_en), .addr(addr),
      .wr(wr), .rd(rd), .wdata(wdata), .pin_in(pin_in), .pin_out(pout_b),
      .rdata(rdata_b), .rdata_oe(oe_b));

   function automatic logic [1:0] mode_of(input int p);
      return CFG[2*p +: 2];
   endfunction

   function automatic bit hit(input logic [7:0] base, input logic [7:0] a);
      return io_req && io_exp_en && (a[7:3] == base[7:3]);
   endfunction

   function automatic logic [8:0] exp_read(input logic [7:0] base, input logic [63:0] lat);
      int p = int'(addr[2:0]);
      if (!(rd && hit(base, addr))) return {1'b0, 8'hFF};
      case (mode_of(p))
         2'd0:    return {1'b1, pin_in[8*p +: 8]};
         2'd2:    return {1'b1, lat[8*p +: 8]};
         default: return {1'b0, 8'hFF};
      endcase
   endfunction

   function automatic logic [63:0] exp_pins(input logic [63:0] lat);
      logic [63:0] r = lat;
      for (int p = 0; p < 8; p++) if (mode_of(p) == 2'd0) r[8*p +: 8] = 8'h00;
      return r;
   endfunction

   function automatic logic [63:0] next_lat(input logic [7:0] base, input logic [63:0] lat);
      logic [63:0] r = lat;
      int p = int'(addr[2:0]);
      if (rst) return '0;
      if (wr && hit(base, addr) && mode_of(p) != 2'd0) r[8*p +: 8] = wdata;
      return r;
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] expv);
      n_chk++;
      if (act !== expv) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, expv);
      end
   endtask

   task automatic step(input logic r_s, input logic q, input logic e, input logic [7:0] a,
                       input logic w, input logic r, input logic [7:0] d, input logic [63:0] pins);
      @(negedge clk);
      rst = r_s; io_req = q; io_exp_en = e; addr = a; wr = w; rd = r; wdata = d; pin_in = pins;
      #1;
      chk("R6 R7 R8 read bank A", {55'd0, oe_a, rdata_a}, {55'd0, exp_read(BASE_A, lat_a)});
      chk("R5 R6 R7 R8 read bank B", {55'd0, oe_b, rdata_b}, {55'd0, exp_read(BASE_B, lat_b)});
      @(posedge clk);
      lat_a = next_lat(BASE_A, lat_a);
      lat_b = next_lat(BASE_B, lat_b);
      #1;
      chk("R1 R2 R3 R9 pins bank A", pout_a, exp_pins(lat_a));
      chk("R1 R2 R3 R5 R9 pins bank B", pout_b, exp_pins(lat_b));
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd7604));
      // R1: reset clears all latches
      step(1, 0, 0, 8'h00, 0, 0, 8'h00, 64'h0);
      step(1, 0, 0, 8'h00, 0, 0, 8'h00, 64'h0);
      chk("R1 reset state A", pout_a, 64'h0);
      // R2/R7: readback port 1
      step(0, 1, 1, 8'h01, 1, 0, 8'hA5, 64'h1111_2222_3333_4444);
      chk("R2 port1 latched", {56'd0, pout_a[15:8]}, 64'hA5);
      step(0, 1, 1, 8'h01, 0, 1, 8'h00, 64'h0F0F_0F0F_0F0F_0F0F);
      chk("R7 readback not pins", {55'd0, oe_a, rdata_a}, {55'd0, 1'b1, 8'hA5});
      // R8: write-only port 6
      step(0, 1, 1, 8'h06, 1, 0, 8'h3C, 64'h0);
      step(0, 1, 1, 8'h06, 0, 1, 8'h00, 64'h0);
      chk("R8 write-only read", {55'd0, oe_a, rdata_a}, {55'd0, 1'b0, 8'hFF});
      chk("R2 port6 latched", {56'd0, pout_a[55:48]}, 64'h3C);
      // R9/R6: input port 0
      step(0, 1, 1, 8'h00, 1, 0, 8'h77, 64'h0);
      chk("R9 input port pins stay 0", {56'd0, pout_a[7:0]}, 64'h0);
      step(0, 1, 1, 8'h00, 0, 1, 8'h00, 64'h0000_0000_0000_005A);
      chk("R6 live input", {55'd0, oe_a, rdata_a}, {55'd0, 1'b1, 8'h5A});
      // R4: enables gate decode
      step(0, 1, 0, 8'h02, 1, 0, 8'hEE, 64'h0);
      chk("R4 exp_en low no write", {56'd0, pout_a[23:16]}, 64'h0);
      step(0, 0, 1, 8'h02, 1, 1, 8'hEE, 64'h0);
      chk("R4 io_req low no write", {56'd0, pout_a[23:16]}, 64'h0);
      chk("R4 io_req low no drive", {63'd0, oe_a}, 64'h0);
      // R5: relocated instance and misses
      step(0, 1, 1, 8'h09, 1, 0, 8'h99, 64'h0);
      step(0, 1, 1, 8'hB3, 1, 0, 8'hC3, 64'h0);
      chk("R5 bank B port3", {56'd0, pout_b[31:24]}, 64'hC3);
      chk("R5 bank A port3 untouched", {56'd0, pout_a[31:24]}, 64'h0);
      step(0, 1, 1, 8'hB3, 0, 1, 8'h00, 64'h0);
      chk("R5 bank B read", {55'd0, oe_b, rdata_b}, {55'd0, 1'b1, 8'hC3});
      // R3: other writes leave port1
      step(0, 1, 1, 8'h02, 1, 0, 8'h12, 64'h0);
      chk("R3 port1 held", {56'd0, pout_a[15:8]}, 64'hA5);
      // random phase
      for (int i = 0; i < 4000; i++) begin
         logic [7:0] a;
         int sel = $urandom_range(3);
         a = $urandom();
         if (sel < 2)       a = {5'd0, a[2:0]};
         else if (sel == 2) a = {5'b10110, a[2:0]};
         step($urandom_range(99) == 0, $urandom_range(9) != 0, $urandom_range(9) != 0, a,
              $urandom_range(1), $urandom_range(1), 8'($urandom()),
              {$urandom(), $urandom()});
      end
      // R1: reset mid-run
      step(1, 1, 1, 8'h01, 1, 0, 8'h55, 64'h0);
      chk("R1 mid-run reset", pout_a | pout_b, 64'h0);
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule